// File: doc/BRIEF.md
# CE-ATA Command Completion Sequencer

This block issues commands on a single-bit, idle-high command line of an SD/MMC-style card interface. It also manages the completion-signal phase that follows a CE-ATA read/write-block command. A command is given as a 6-bit index, a 32-bit argument and three flags. The first flag holds the command until the previous data transfer has finished. The second turns on response CRC checking. The third marks a command that is followed by a completion-signal wait. The block serialises a 48-bit frame with its CRC7, releases the line and captures the 48-bit short response.

During the completion wait, a low level on the line counts as the card's completion signal. Software can instead cancel the wait with a disable request. The block then drives a short disable pattern. If the automatic-stop control is set at that moment, the pattern is followed at once by an internally built stop command (index 12, argument zero), and an auto-command-done status bit is raised. Status bits are write-1-to-clear. A new command is refused while any phase is in progress.

Top module: `ccs_cmd_seq`

## Requirements
- R1: An accepted command is driven as a 48-bit frame, MSB first, one bit per clock, with `cmd_oe` high, starting in the cycle after acceptance. The frame is, from first to last: bit 0, bit 1, the 6-bit index, the 32-bit argument, CRC7 (polynomial x^7+x^3+1, zero seed) over the first 40 bits, and bit 1.
- R2: With `cmd_wait_prv` at 0 the frame starts in the cycle after acceptance. With it at 1 the frame is held until a `data_done` pulse has been seen since the last such wait was served.
- R3: After the frame the line is released (`cmd_oe` low). The first 0 sampled on `cmd_in` starts a 48-bit response capture. At its end `irq_sts[0]` is set, and `resp_index`/`resp_arg` show bits 45..40 and 39..8 of the response.
- R4: `irq_sts[1]` (CRC error) is set with `irq_sts[0]` only if `cmd_chk_crc` was 1 and the response's bits 7..1 differ from CRC7 of its bits 47..8. With `cmd_chk_crc` at 0 it is never set.
- R5: For a command with `cmd_ccs_exp` at 1, a low `cmd_in` after the response, with no disable pending, sets `irq_sts[2]` and ends the operation.
- R6: A `ccsd_req` pulse stays pending until the completion wait of a `cmd_ccs_exp` command. Only then does the block drive the pattern 0,0,0,0,1 for five clocks. Nothing is driven before the response is captured.
- R7: If `auto_stop` is 1 when the disable pattern starts, the stop frame (index 12, argument 0) follows with no gap, and `irq_sts[3]` is set on the clock edge that ends its last bit. If `auto_stop` is 0, the operation ends after the pattern and `irq_sts[3]` stays 0.
- R8: Writing 1 to a bit of `irq_clr` clears that status bit on the next edge. Other bits are kept.
- R9: `cmd_accept` is high only when `busy` is low. A command offered while busy is dropped and causes no frame.
- R10: After reset `cmd_oe`=0, `cmd_out`=1, `busy`=0 and `irq_sts`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_wait_prv | input | 1 | Hold until previous data transfer done |
| cmd_chk_crc | input | 1 | Check response CRC |
| cmd_ccs_exp | input | 1 | Completion-signal wait follows response |
| cmd_accept | output | 1 | Command taken this cycle |
| busy | output | 1 | An operation is in progress |
| data_done | input | 1 | Pulse: previous data transfer finished |
| ccsd_req | input | 1 | Pulse: request completion-signal disable |
| auto_stop | input | 1 | Send stop command after disable pattern |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Driven command line value |
| cmd_oe | output | 1 | Command line drive enable |
| irq_clr | input | 4 | Write-1-to-clear for status bits |
| irq_sts | output | 4 | Status: 0 resp done, 1 CRC error, 2 completion seen, 3 auto-command done |
| resp_index | output | 6 | Index field of last response |
| resp_arg | output | 32 | Argument field of last response |

## Verification
A sequencer stuck in a wrong phase shows at once on `cmd_oe`. The line is either driven where the card should own it, or left released where a frame or the disable pattern is due. So bit-by-bit sampling of every frame exposes the fault within one clock. A misplaced shift or CRC step corrupts a captured frame bit. A wrongly kept or lost pending disable request shows up as a missing or early pattern after the response. Status faults appear on `irq_sts` two edges after the last response bit, or on the edge that ends the stop frame.

// File: rtl/ccs_pkg.sv
// Shared constants, sequencer state type and frame-building helpers.
// Assumes 48-bit short frames with a 40-bit CRC-covered head.
package ccs_pkg;
    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int FRAME_W = 2 + IDX_W + ARG_W + CRC_W + 1;
    localparam int HEAD_W  = 2 + IDX_W + ARG_W;
    localparam int PAT_W   = 5;
    localparam int STS_W   = 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam logic [PAT_W-1:0] DIS_PATTERN = 5'b00001;
    localparam logic [IDX_W-1:0] STOP_IDX    = 6'd12;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HOLD, ST_SEND, ST_RESP, ST_CCSW, ST_CCSD, ST_STOP
    } seq_st_t;

    // CRC7 (x^7+x^3+1) over the frame head, MSB first, zero seed.
    function automatic logic [CRC_W-1:0] crc7_calc(input logic [HEAD_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '0;
        for (int i = HEAD_W - 1; i >= 0; i--) begin
            fb = d[i] ^ c[CRC_W-1];
            c  = {c[5:3], c[2] ^ fb, c[1:0], fb};
        end
        return c;
    endfunction

    // Host-to-card frame: start 0, direction 1, index, argument, CRC7, end 1.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [IDX_W-1:0] idx,
                                                       input logic [ARG_W-1:0] arg);
        logic [HEAD_W-1:0] h;
        h = {2'b01, idx, arg};
        return {h, crc7_calc(h), 1'b1};
    endfunction
endpackage

// File: rtl/ccs_tx_shift.sv
// Parallel-load, MSB-first serialiser for the command line.
// Loads a left-aligned vector and a bit count; shifts one bit per clock.
// A load in the last-bit cycle chains the next vector with no gap.
module ccs_tx_shift #(
    parameter int W   = 48,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     ld_vec,
    input  logic [CNT_W-1:0] ld_len,
    output logic             ser_out,
    output logic             active,
    output logic             last
);
    logic [W-1:0]     sreg;
    logic [CNT_W-1:0] left;

    // Shift register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            left   <= '0;
            active <= 1'b0;
        end else if (load) begin
            sreg   <= ld_vec;
            left   <= ld_len;
            active <= 1'b1;
        end else if (active) begin
            sreg <= {sreg[W-2:0], 1'b0};
            left <= left - 1'b1;
            if (left == CNT_W'(1)) active <= 1'b0;
        end
    end

    assign ser_out = sreg[W-1];
    assign last    = active && (left == CNT_W'(1));
endmodule

// File: rtl/ccs_rx_capture.sv
// Short-response capture: while enabled, a low sample begins a W-bit
// frame (start bit included); done pulses one cycle after the last bit.
// Assumes the line idles high once the frame is over.
module ccs_rx_capture #(
    parameter int W = 48,
    parameter int CNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         line,
    output logic [W-1:0] frame,
    output logic         done
);
    logic             cap;
    logic [CNT_W-1:0] got;

    // Start detection, bit shifting and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap   <= 1'b0;
            got   <= '0;
            frame <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cap) begin
                frame <= {frame[W-2:0], line};
                if (got == CNT_W'(W - 1)) begin
                    cap  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    got <= got + 1'b1;
                end
            end else if (en && !line && !done) begin
                frame <= {frame[W-2:0], line};
                got   <= CNT_W'(1);
                cap   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccs_cmd_seq.sv
// Command sequencer with completion-signal handling for CE-ATA block
// commands. Sends a frame, captures the short response, then waits for
// the completion signal or cancels it with the disable pattern and an
// optional internal stop command. Assumes an external pull-up on the line.
module ccs_cmd_seq
    import ccs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [IDX_W-1:0] cmd_index,
    input  logic [ARG_W-1:0] cmd_arg,
    input  logic             cmd_wait_prv,
    input  logic             cmd_chk_crc,
    input  logic             cmd_ccs_exp,
    output logic             cmd_accept,
    output logic             busy,
    input  logic             data_done,
    input  logic             ccsd_req,
    input  logic             auto_stop,
    input  logic             cmd_in,
    output logic             cmd_out,
    output logic             cmd_oe,
    input  logic [STS_W-1:0] irq_clr,
    output logic [STS_W-1:0] irq_sts,
    output logic [IDX_W-1:0] resp_index,
    output logic [ARG_W-1:0] resp_arg
);
    seq_st_t              st;
    logic [IDX_W-1:0]     idx_q;
    logic [ARG_W-1:0]     arg_q;
    logic                 chk_q, ccs_q, auto_q, pend_q, dto_q;
    logic                 tx_load, tx_ser, tx_act, tx_last, dto_take;
    logic [FRAME_W-1:0]   tx_vec;
    logic [LEN_W-1:0]     tx_len;
    logic [FRAME_W-1:0]   rx_frame;
    logic                 rx_done, rx_bad, resp_end, dis_take;
    logic [STS_W-1:0]     sts_set;

    assign cmd_accept = cmd_valid && (st == ST_IDLE);
    assign busy       = (st != ST_IDLE);
    assign resp_end   = rx_done && (st == ST_RESP);
    assign rx_bad     = crc7_calc(rx_frame[FRAME_W-1:FRAME_W-HEAD_W]) != rx_frame[CRC_W:1];
    assign dis_take   = (st == ST_CCSW) && pend_q;

    // Choose what the serialiser loads this cycle, if anything.
    always_comb begin
        tx_load  = 1'b0;
        dto_take = 1'b0;
        tx_vec   = build_frame(idx_q, arg_q);
        tx_len   = LEN_W'(FRAME_W);
        unique case (st)
            ST_IDLE: if (cmd_valid && !(cmd_wait_prv && !dto_q)) begin
                tx_load  = 1'b1;
                dto_take = cmd_wait_prv;
                tx_vec   = build_frame(cmd_index, cmd_arg);
            end
            ST_HOLD: if (dto_q) begin
                tx_load  = 1'b1;
                dto_take = 1'b1;
            end
            ST_CCSW: if (pend_q) begin
                tx_load = 1'b1;
                tx_vec  = {DIS_PATTERN, {(FRAME_W-PAT_W){1'b0}}};
                tx_len  = LEN_W'(PAT_W);
            end
            ST_CCSD: if (tx_last && auto_q) begin
                tx_load = 1'b1;
                tx_vec  = build_frame(STOP_IDX, '0);
            end
            default: ;
        endcase
    end

    // Phase sequencing and latching of the command descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            idx_q  <= '0;
            arg_q  <= '0;
            chk_q  <= 1'b0;
            ccs_q  <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    idx_q <= cmd_index;
                    arg_q <= cmd_arg;
                    chk_q <= cmd_chk_crc;
                    ccs_q <= cmd_ccs_exp;
                    st    <= tx_load ? ST_SEND : ST_HOLD;
                end
                ST_HOLD: if (tx_load) st <= ST_SEND;
                ST_SEND: if (tx_last) st <= ST_RESP;
                ST_RESP: if (rx_done) st <= ccs_q ? ST_CCSW : ST_IDLE;
                ST_CCSW: begin
                    if (pend_q) begin
                        auto_q <= auto_stop;
                        st     <= ST_CCSD;
                    end else if (!cmd_in) begin
                        st <= ST_IDLE;
                    end
                end
                ST_CCSD: if (tx_last) st <= auto_q ? ST_STOP : ST_IDLE;
                ST_STOP: if (tx_last) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Sticky data-done and disable-request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dto_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            dto_q  <= data_done | (dto_q & ~dto_take);
            pend_q <= ccsd_req | (pend_q & ~dis_take);
        end
    end

    // Status set terms: resp, CRC error, completion seen, auto-command done.
    always_comb begin
        sts_set[0] = resp_end;
        sts_set[1] = resp_end && chk_q && rx_bad;
        sts_set[2] = (st == ST_CCSW) && !pend_q && !cmd_in;
        sts_set[3] = (st == ST_STOP) && tx_last;
    end

    // Write-1-to-clear status and response field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sts    <= '0;
            resp_index <= '0;
            resp_arg   <= '0;
        end else begin
            irq_sts <= (irq_sts & ~irq_clr) | sts_set;
            if (resp_end) begin
                resp_index <= rx_frame[FRAME_W-3 -: IDX_W];
                resp_arg   <= rx_frame[CRC_W+1 +: ARG_W];
            end
        end
    end

    ccs_tx_shift #(.W(FRAME_W), .CNT_W(LEN_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .ld_vec(tx_vec), .ld_len(tx_len),
        .ser_out(tx_ser), .active(tx_act), .last(tx_last)
    );

    ccs_rx_capture #(.W(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(st == ST_RESP), .line(cmd_in),
        .frame(rx_frame), .done(rx_done)
    );

    assign cmd_oe  = tx_act;
    assign cmd_out = tx_act ? tx_ser : 1'b1;
endmodule

// File: rtl/ccs_cmd_seq_chk.sv
// Port-level temporal checks for ccs_cmd_seq, attached by bind.
module ccs_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_accept,
    input logic       busy,
    input logic       cmd_in,
    input logic       cmd_out,
    input logic       cmd_oe,
    input logic [3:0] irq_sts
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_oe);
    assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> !busy);
    assert_first_bit_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    assert_crcerr_with_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sts[1]) |-> irq_sts[0]);
    assert_ccs_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sts[2]) |-> ($past(!cmd_in) && !busy));
    assert_acd_after_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_sts[3]) |-> ($past(cmd_oe) && !cmd_oe));
endmodule

bind ccs_cmd_seq ccs_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept), .busy(busy),
    .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .irq_sts(irq_sts)
);

// File: tb/sim_ccs_cmd_seq.sv
// Directed bench: one task per scenario, card side modelled by tasks.
module sim_ccs_cmd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_wait_prv = 1'b0, cmd_chk_crc = 1'b0, cmd_ccs_exp = 1'b0;
    logic        cmd_accept, busy;
    logic        data_done = 1'b0, ccsd_req = 1'b0, auto_stop = 1'b0;
    logic        cmd_in = 1'b1;
    logic        cmd_out, cmd_oe;
    logic [3:0]  irq_clr = '0;
    logic [3:0]  irq_sts;
    logic [5:0]  resp_index;
    logic [31:0] resp_arg;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ccs_cmd_seq u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] r = 7'd0;
        for (int i = 39; i >= 0; i--) begin
            logic top = r[6] ^ d[i];
            r = {r[5:0], 1'b0};
            if (top) r = r ^ 7'h09;
        end
        return r;
    endfunction

    function automatic logic [47:0] host_frame(input logic [5:0] i, input logic [31:0] a);
        return {2'b01, i, a, ref_crc({2'b01, i, a}), 1'b1};
    endfunction

    task automatic issue(input logic [5:0] i, input logic [31:0] a, input bit w,
                         input bit c, input bit s, output logic acc);
        @(negedge clk);
        cmd_valid = 1; cmd_index = i; cmd_arg = a;
        cmd_wait_prv = w; cmd_chk_crc = c; cmd_ccs_exp = s;
        #1 acc = cmd_accept;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_oe();
        for (int k = 0; k < 60 && !cmd_oe; k++) @(negedge clk);
    endtask

    // Samples n line bits starting at the current negedge; oe_all tracks drive.
    task automatic grab(input int n, output logic [63:0] v, output bit oe_all);
        v = '0; oe_all = 1;
        for (int k = 0; k < n; k++) begin
            v = {v[62:0], cmd_out};
            if (!cmd_oe) oe_all = 0;
            if (k < n - 1) @(negedge clk);
        end
    endtask

    task automatic card_resp(input logic [5:0] i, input logic [31:0] a, input bit bad);
        logic [47:0] f;
        f = {2'b00, i, a, ref_crc({2'b00, i, a}), 1'b1};
        if (bad) f[1] = ~f[1];
        repeat (2) @(negedge clk);
        for (int k = 47; k >= 0; k--) begin
            cmd_in = f[k];
            @(negedge clk);
        end
        cmd_in = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); irq_clr = 4'hF;
        @(negedge clk); irq_clr = 4'h0;
    endtask

    task automatic t_reset();
        chk("R10 cmd_oe", 64'(cmd_oe), 64'd0);
        chk("R10 cmd_out", 64'(cmd_out), 64'd1);
        chk("R10 busy", 64'(busy), 64'd0);
        chk("R10 irq_sts", 64'(irq_sts), 64'd0);
    endtask

    task automatic t_plain();
        logic acc; logic [63:0] v; bit oe_all;
        issue(6'd17, 32'h1234_5678, 0, 1, 0, acc);
        chk("R9 accept when idle", 64'(acc), 64'd1);
        chk("R2 immediate start", 64'(cmd_oe), 64'd1);
        grab(48, v, oe_all);
        chk("R1 frame bits", v, 64'(host_frame(6'd17, 32'h1234_5678)));
        chk("R1 oe over frame", 64'(oe_all), 64'd1);
        @(negedge clk);
        chk("R3 line released", 64'(cmd_oe), 64'd0);
        cmd_valid = 1; cmd_index = 6'd5; #1;
        chk("R9 reject while busy", 64'(cmd_accept), 64'd0);
        @(negedge clk); cmd_valid = 0;
        card_resp(6'd17, 32'hCAFE_0042, 0);
        chk("R3 resp done", 64'(irq_sts), 64'h1);
        chk("R3 resp index", 64'(resp_index), 64'd17);
        chk("R3 resp arg", 64'(resp_arg), 64'hCAFE_0042);
        chk("R3 back idle", 64'(busy), 64'd0);
        repeat (5) @(negedge clk);
        chk("R9 dropped command sends nothing", 64'(cmd_oe), 64'd0);
        clear_all();
        chk("R8 clear all", 64'(irq_sts), 64'd0);
    endtask

    task automatic t_crc();
        logic acc; logic [63:0] v; bit oe_all;
        issue(6'd13, 32'h0000_0001, 0, 1, 0, acc);
        grab(48, v, oe_all);
        card_resp(6'd13, 32'h0000_0900, 1);
        chk("R4 crc error flagged", 64'(irq_sts), 64'h3);
        @(negedge clk); irq_clr = 4'h2;
        @(negedge clk); irq_clr = 4'h0;
        chk("R8 clear only crc bit", 64'(irq_sts), 64'h1);
        clear_all();
        issue(6'd13, 32'h0000_0002, 0, 0, 0, acc);
        grab(48, v, oe_all);
        card_resp(6'd13, 32'h0000_0900, 1);
        chk("R4 crc ignored when off", 64'(irq_sts), 64'h1);
        clear_all();
    endtask

    task automatic t_wait();
        logic acc; logic [63:0] v; bit oe_all; bit early;
        issue(6'd24, 32'h0000_0100, 1, 1, 0, acc);
        early = 0;
        for (int k = 0; k < 10; k++) begin
            if (cmd_oe) early = 1;
            @(negedge clk);
        end
        chk("R2 held before data_done", 64'(early), 64'd0);
        data_done = 1;
        @(negedge clk); data_done = 0;
        @(negedge clk);
        chk("R2 released after data_done", 64'(cmd_oe), 64'd1);
        grab(48, v, oe_all);
        chk("R2 held frame bits", v, 64'(host_frame(6'd24, 32'h0000_0100)));
        card_resp(6'd24, 32'h0, 0);
        clear_all();
    endtask

    task automatic t_ccs();
        logic acc; logic [63:0] v; bit oe_all;
        issue(6'd24, 32'h0000_0200, 0, 1, 1, acc);
        grab(48, v, oe_all);
        card_resp(6'd24, 32'h0, 0);
        chk("R5 waiting for completion", 64'(busy), 64'd1);
        repeat (3) @(negedge clk);
        cmd_in = 0;
        @(negedge clk); cmd_in = 1;
        chk("R5 completion status", 64'(irq_sts), 64'h5);
        chk("R5 idle after completion", 64'(busy), 64'd0);
        clear_all();
    endtask

    task automatic t_disable(input bit with_stop);
        logic acc; logic [63:0] v; bit oe_all;
        issue(6'd25, 32'h0000_0300, 0, 1, 1, acc);
        ccsd_req = 1; auto_stop = with_stop;
        @(negedge clk); ccsd_req = 0;
        chk("R6 no pattern during frame", 64'(cmd_out), 64'(host_frame(6'd25, 32'h300)[46]));
        grab(47, v, oe_all);
        @(negedge clk);
        chk("R6 not honoured before response", 64'(cmd_oe), 64'd0);
        card_resp(6'd25, 32'h0, 0);
        wait_oe();
        if (with_stop) begin
            grab(53, v, oe_all);
            chk("R7 pattern then stop frame", v, {11'd0, 5'b00001, host_frame(6'd12, 32'd0)});
            chk("R7 no gap", 64'(oe_all), 64'd1);
            chk("R7 acd not before end", 64'(irq_sts[3]), 64'd0);
            @(negedge clk);
            chk("R7 acd set", 64'(irq_sts), 64'h9);
        end else begin
            grab(5, v, oe_all);
            chk("R6 disable pattern", v, 64'h01);
            @(negedge clk);
            chk("R7 no stop without auto", 64'(cmd_oe), 64'd0);
            chk("R7 acd stays low", 64'(irq_sts), 64'h1);
        end
        chk("R6 idle after disable", 64'(busy), 64'd0);
        auto_stop = 0;
        clear_all();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_crc();
        t_wait();
        t_ccs();
        t_disable(1);
        t_disable(0);
        finished = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end
endmodule